// File: doc/BRIEF.md
# ATA Task-File Command Sequencer

This block is the device side of an ATA task-file register interface for a single fixed disk answering as drive 0. A host reaches it through a simple register port: an 8-bit write path and a 16-bit read path, selected by a 3-bit offset, one access per clock cycle. Behind the port sit the task-file bytes, an error byte, a status byte and a small sequencer. The sequencer carries out the device-identification command, whose 256-word response is read one word at a time through the data offset. It also carries out the cache-flush command, which keeps the device busy until an outside agent pulses a completion strobe. Any other opcode is aborted.

Read data is combinational from the offset, so a read is seen in the cycle it is issued. Reads of the data and status offsets have side effects that take effect at the clock edge that ends the access. A data read advances the response pointer, and a status read acknowledges the interrupt. The interrupt line is a level that stays high until the status byte is read. The flush request output is a level and needs no handshake. The device holds it high for as long as the flush is outstanding, and the agent answers with a single-cycle done pulse. The register port has no back-pressure, because every access completes in its own cycle.

Top module: `ata_tf_seq`

## Requirements
- R1: Offsets are 0 data, 1 error on read (feature on write), 2 sector count, 3/4/5 address low/mid/high, 6 device select, 7 status on read (command on write). Status bits are busy 0x80, ready 0x40, fault 0x20, data-request 0x08, error 0x01. After reset, status reads 0x40, error reads 0x00, and irq and flush_req are low.
- R2: Bytes written to offsets 2 to 6 read back unchanged on the same offset, in the low byte with the high byte zero. A write to these offsets while busy or data-request is set is ignored.
- R3: Opcode 0xEC is identify. When it is accepted, data-request is set and irq rises. Before each of the 256 data reads, status reads 0x48. After the 256th data read, status reads 0x40.
- R4: Identify word 0 is 0x0040. Words 10 to 19 hold the 20-character serial parameter and words 23 to 26 hold the 8-character version parameter, two characters per word with the earlier character in the high byte. Word 85 is 0x0020 (write cache on). Every other word is 0x0000.
- R5: Opcode 0xE7 is flush. While it is outstanding, status reads 0xC0 and flush_req is high. The cycle after a flush_done pulse, flush_req is low, status reads 0x40 and irq is high.
- R6: Any other opcode is aborted: status reads 0x41, error reads 0x04 and irq rises. The next accepted valid command clears both the error bit and the error byte.
- R7: A status read clears irq at the end of the access. If an interrupt event happens in the same cycle, the event wins and irq stays high.
- R8: A command write is ignored while busy or data-request is set. It is also ignored when device-select bit 0x10 is set (drive 1).
- R9: A data read outside an identify transfer returns 0x0000 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects at cycle end) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| irq | output | 1 | Interrupt request level |
| flush_req | output | 1 | Flush outstanding |
| flush_done | input | 1 | Single-cycle flush completion pulse |

## Verification
The assertions watch the following on every cycle:
- The busy and data-request states never overlap.
- flush_req is held until the done pulse arrives.
- A status read with no simultaneous event leaves irq low.
- The error bit always comes with the abort code.
- The last data read returns the sequencer to idle.
- Locked task-file bytes hold still.

Only the bench scenarios can show the full identify image, the status value seen before each word read, the priority between a flush completion and a status read in the same cycle, and which command writes are ignored.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam logic [7:0] ST_BUSY  = 8'h80;
  localparam logic [7:0] ST_READY = 8'h40;
  localparam logic [7:0] ST_DREQ  = 8'h08;
  localparam logic [7:0] ST_ERR   = 8'h01;
  localparam logic [7:0] ERR_ABORT = 8'h04;
  localparam logic [7:0] OP_IDENT = 8'hEC;
  localparam logic [7:0] OP_FLUSH = 8'hE7;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_ERR  = 3'd1;
  localparam logic [2:0] OFS_DEV  = 3'd6;
  localparam logic [2:0] OFS_CMD  = 3'd7;
  localparam int DRIVE_BIT = 4;
  typedef enum logic [1:0] {SQ_IDLE, SQ_XFER, SQ_FLUSH} seq_state_t;
endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  input  logic       lock,
  output logic [6:1][7:0] file_q
);
  for (genvar g = 1; g <= 6; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) file_q[g] <= 8'h00;
      else if (wr_en && !lock && addr == 3'(g)) file_q[g] <= wdata;
    end
  end

  p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && wr_en) |=> $stable(file_q));
endmodule

// File: rtl/ata_ident_rom.sv
module ata_ident_rom #(
  parameter int IDX_W = 8,
  parameter int SER_CHARS = 20,
  parameter int VER_CHARS = 8,
  parameter int SER_BASE = 10,
  parameter int VER_BASE = 23,
  parameter int CACHE_WORD = 85,
  parameter logic [8*SER_CHARS-1:0] SERIAL = "0000000000          ",
  parameter logic [8*VER_CHARS-1:0] VERSION = "1.0     ",
  parameter bit WCACHE_ON = 1'b1
) (
  input  logic [IDX_W-1:0] idx,
  output logic [15:0]      word
);
  localparam int SER_WORDS = SER_CHARS / 2;
  localparam int VER_WORDS = VER_CHARS / 2;
  int pos;
  int rel;

  always_comb begin
    pos  = int'(idx);
    rel  = 0;
    word = 16'h0000;
    if (pos == 0) begin
      word = 16'h0040;
    end else if (pos >= SER_BASE && pos < SER_BASE + SER_WORDS) begin
      rel  = pos - SER_BASE;
      word = SERIAL[8*SER_CHARS-1-16*rel -: 16];
    end else if (pos >= VER_BASE && pos < VER_BASE + VER_WORDS) begin
      rel  = pos - VER_BASE;
      word = VERSION[8*VER_CHARS-1-16*rel -: 16];
    end else if (pos == CACHE_WORD) begin
      word = WCACHE_ON ? 16'h0020 : 16'h0000;
    end
  end
endmodule

// File: rtl/ata_cmd_fsm.sv
module ata_cmd_fsm
  import ata_tf_pkg::*;
#(
  parameter int WORDS = 256,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_byte,
  input  logic             drive_one,
  input  logic             data_rd,
  input  logic             stat_rd,
  input  logic             flush_done,
  output seq_state_t       state_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             err_q,
  output logic [7:0]       error_q,
  output logic             irq,
  output logic             flush_req
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

  logic accept;
  logic irq_set;
  logic irq_q;

  assign accept = cmd_wr && (state_q == SQ_IDLE) && !drive_one;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      err_q   <= 1'b0;
      error_q <= 8'h00;
    end else begin
      case (state_q)
        SQ_IDLE: if (accept) begin
          if (cmd_byte == OP_IDENT) begin
            state_q <= SQ_XFER;
            idx_q   <= '0;
            err_q   <= 1'b0;
            error_q <= 8'h00;
          end else if (cmd_byte == OP_FLUSH) begin
            state_q <= SQ_FLUSH;
            err_q   <= 1'b0;
            error_q <= 8'h00;
          end else begin
            err_q   <= 1'b1;
            error_q <= ERR_ABORT;
          end
        end
        SQ_XFER: if (data_rd) begin
          if (idx_q == LAST) state_q <= SQ_IDLE;
          else idx_q <= idx_q + 1'b1;
        end
        SQ_FLUSH: if (flush_done) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    irq_set = 1'b0;
    if (accept && cmd_byte != OP_FLUSH) irq_set = 1'b1;
    if (state_q == SQ_FLUSH && flush_done) irq_set = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else if (irq_set) irq_q <= 1'b1;
    else if (stat_rd) irq_q <= 1'b0;
  end

  assign irq = irq_q;
  assign flush_req = (state_q == SQ_FLUSH);

  p_flush_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_done) |=> flush_req);
  p_irq_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !cmd_wr && !flush_done) |=> !irq);
  p_abort_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (error_q == ERR_ABORT));
  p_last_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && state_q == SQ_XFER && idx_q == LAST) |=> (state_q == SQ_IDLE));
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_FLUSH && cmd_wr && !flush_done) |=> (state_q == SQ_FLUSH));
endmodule

// File: rtl/ata_tf_seq.sv
module ata_tf_seq
  import ata_tf_pkg::*;
#(
  parameter int WORDS = 256,
  parameter logic [159:0] SERIAL = "0000000000          ",
  parameter logic [63:0]  VERSION = "1.0     ",
  parameter bit WCACHE_ON = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  output logic        flush_req,
  input  logic        flush_done
);
  localparam int IDX_W = $clog2(WORDS);

  seq_state_t       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             err_q;
  logic [7:0]       error_q;
  logic [6:1][7:0]  file_q;
  logic [15:0]      ident_word;
  logic [7:0]       status;
  logic             busy;
  logic             dreq;

  assign busy = (state_q == SQ_FLUSH);
  assign dreq = (state_q == SQ_XFER);
  assign status = (busy ? ST_BUSY : 8'h00) | ST_READY |
                  (dreq ? ST_DREQ : 8'h00) | (err_q ? ST_ERR : 8'h00);

  ata_tf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .lock(busy || dreq), .file_q(file_q)
  );

  ata_ident_rom #(
    .IDX_W(IDX_W), .SERIAL(SERIAL), .VERSION(VERSION), .WCACHE_ON(WCACHE_ON)
  ) u_rom (
    .idx(idx_q), .word(ident_word)
  );

  ata_cmd_fsm #(.WORDS(WORDS), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(bus_wr && bus_addr == OFS_CMD), .cmd_byte(bus_wdata),
    .drive_one(file_q[6][DRIVE_BIT]),
    .data_rd(bus_rd && bus_addr == OFS_DATA),
    .stat_rd(bus_rd && bus_addr == OFS_CMD),
    .flush_done(flush_done),
    .state_q(state_q), .idx_q(idx_q), .err_q(err_q), .error_q(error_q),
    .irq(irq), .flush_req(flush_req)
  );

  always_comb begin
    case (bus_addr)
      OFS_DATA: bus_rdata = dreq ? ident_word : 16'h0000;
      OFS_ERR:  bus_rdata = {8'h00, error_q};
      OFS_CMD:  bus_rdata = {8'h00, status};
      default:  bus_rdata = {8'h00, file_q[bus_addr]};
    endcase
  end

  p_excl_states_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[7] && status[3]));
  p_ready_always_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_CMD) |-> bus_rdata[6]);
endmodule

// File: tb/ata_tf_seq_tb_top.sv
module ata_tf_seq_tb_top;
  localparam logic [159:0] SER = "UNIT-0042           ";
  localparam logic [63:0]  VER = "REV 1.07";
  localparam int NW = 256;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, flush_done = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic irq, flush_req;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  ata_tf_seq #(.WORDS(NW), .SERIAL(SER), .VERSION(VER), .WCACHE_ON(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .flush_req(flush_req), .flush_done(flush_done)
  );

  // offset in [10:8], value in [7:0]
  localparam logic [10:0] VEC [5] = '{
    {3'd2, 8'h01}, {3'd3, 8'h23}, {3'd4, 8'h45}, {3'd5, 8'h67}, {3'd6, 8'h40}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  function automatic logic [15:0] exp_word(input int i);
    if (i == 0) return 16'h0040;
    if (i >= 10 && i < 20) return SER[159-16*(i-10) -: 16];
    if (i >= 23 && i < 27) return VER[63-16*(i-23) -: 16];
    if (i == 85) return 16'h0020;
    return 16'h0000;
  endfunction

  initial begin
    #(4*150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(3'd7, v); chk("R1 status", v, 16'h0040);
    rd(3'd1, v); chk("R1 error", v, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0000);
    chk("R1 flush_req", {15'b0, flush_req}, 16'h0000);
    // R2 table walk
    for (int k = 0; k < 5; k++) wr(VEC[k][10:8], VEC[k][7:0]);
    for (int k = 0; k < 5; k++) begin
      rd(VEC[k][10:8], v); chk("R2 readback", v, {8'h00, VEC[k][7:0]});
    end
    // R9 data read idle
    rd(3'd0, v); chk("R9 idle data", v, 16'h0000);
    rd(3'd7, v); chk("R9 status unchanged", v, 16'h0040);
    // R8 drive 1 selected
    wr(3'd6, 8'h50); wr(3'd7, 8'hEC);
    rd(3'd7, v); chk("R8 drive1 ignored", v, 16'h0040);
    chk("R8 no irq", {15'b0, irq}, 16'h0000);
    wr(3'd6, 8'h40);
    // R3 identify
    wr(3'd7, 8'hEC);
    chk("R3 irq on accept", {15'b0, irq}, 16'h0001);
    wr(3'd2, 8'h99);              // R2 locked write
    wr(3'd7, 8'hE7);              // R8 ignored during transfer
    chk("R8 no flush in xfer", {15'b0, flush_req}, 16'h0000);
    for (int i = 0; i < NW; i++) begin
      rd(3'd7, v); chk("R3 status per word", v, 16'h0048);
      rd(3'd0, v); chk("R4 ident word", v, exp_word(i));
    end
    chk("R7 irq cleared", {15'b0, irq}, 16'h0000);
    rd(3'd7, v); chk("R3 status after last", v, 16'h0040);
    rd(3'd2, v); chk("R2 locked write ignored", v, 16'h0001);
    // R5 flush
    wr(3'd7, 8'hE7);
    rd(3'd7, v); chk("R5 status busy", v, 16'h00C0);
    chk("R5 flush_req", {15'b0, flush_req}, 16'h0001);
    wr(3'd7, 8'hEC);              // R8 ignored while busy
    rd(3'd7, v); chk("R8 busy ignore", v, 16'h00C0);
    @(negedge clk); flush_done = 1; @(negedge clk); flush_done = 0;
    chk("R5 flush_req low", {15'b0, flush_req}, 16'h0000);
    chk("R5 irq", {15'b0, irq}, 16'h0001);
    rd(3'd7, v); chk("R5 status done", v, 16'h0040);
    chk("R7 irq acked", {15'b0, irq}, 16'h0000);
    // R7 event wins over simultaneous status read
    wr(3'd7, 8'hE7);
    @(negedge clk); flush_done = 1; bus_rd = 1; bus_addr = 3'd7;
    @(negedge clk); flush_done = 0; bus_rd = 0;
    chk("R7 event wins", {15'b0, irq}, 16'h0001);
    rd(3'd7, v);
    chk("R7 cleared after", {15'b0, irq}, 16'h0000);
    // R6 abort
    wr(3'd7, 8'h55);
    rd(3'd1, v); chk("R6 error abrt", v, 16'h0004);
    chk("R6 irq", {15'b0, irq}, 16'h0001);
    rd(3'd7, v); chk("R6 status err", v, 16'h0041);
    wr(3'd7, 8'hE7);
    rd(3'd7, v); chk("R6 err cleared", v, 16'h00C0);
    rd(3'd1, v); chk("R6 error cleared", v, 16'h0000);
    @(negedge clk); flush_done = 1; @(negedge clk); flush_done = 0;
    rd(3'd7, v); chk("R6 final status", v, 16'h0040);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule